// File: doc/BRIEF.md
# Filter Address Bank with Lane-Triggered Clock-Domain Transfer

This block holds a small bank of 32-bit filter address words. Software writes them from a host clock domain over a plain byte-enabled write port. Each word also has a copy in a separate receive clock domain, where packet filters read it. There are two filter sets. Each set has four layer-3 address words and one layer-4 port word. Word index `set*5 + w` selects a register: `w` = 0..3 are the layer-3 words and `w` = 4 is the port word. For an IPv4 filter, word 0 is the source and word 1 the destination. For IPv6, words 0..3 carry address bits [31:0], [63:32], [95:64] and [127:96].

A host write merges only the enabled bytes into the host-side word. A write moves the word into the receive domain only when it enables the trigger byte lane. That lane is bits [31:24] in little-endian mode and bits [7:0] in big-endian mode. The transfer flips a per-register request toggle. The toggle crosses a two-flop synchronizer and is edge-detected in the receive domain, which then loads the copy from the host-side word. The host-side word is held steady while the request is in flight. The acknowledge crosses back the same way, and a per-register busy bit tells software when it may write that register again.

Top module: `addr_bank_cdc`

## Requirements
- R1: After both resets, every receive-side copy is zero and every busy and overrun bit is 0.
- R2: With `big_end_i`=0, a write whose `wr_be_i[3]` is 1 makes the receive-side copy equal the merged host word within four receive clocks.
- R3: With `big_end_i`=1, a write whose `wr_be_i[0]` is 1 triggers the transfer. A big-endian write with `wr_be_i[0]`=0 does not trigger it, even when `wr_be_i[3]` is 1.
- R4: A write that does not enable the trigger lane leaves the receive-side copy unchanged. Its bytes are kept in the host word and are carried over by the next triggering write.
- R5: `busy_o[r]` is 1 from the host clock edge after a triggering write to register r, and returns to 0 once the acknowledge has come back.
- R6: A write to a register whose busy bit is 1 is dropped and leaves the host word unchanged. If that write enables the trigger lane, it sets `overrun_o[r]`, which stays 1 until host reset.
- R7: A write with `wr_addr_i` >= 10 changes no register and raises no busy bit.
- R8: Byte k of a register (bits [8k+7:8k]) is written only when `wr_be_i[k]` is 1. A write to register r changes no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk_i | input | 1 | Host clock |
| hrst_ni | input | 1 | Host-domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Register index, set*5+word |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Byte enables, bit k for bits [8k+7:8k] |
| big_end_i | input | 1 | Trigger lane select: 0 selects byte 3, 1 selects byte 0 |
| busy_o | output | 10 | Per-register transfer in flight |
| overrun_o | output | 10 | Per-register sticky overrun |
| rclk_i | input | 1 | Receive clock |
| rrst_ni | input | 1 | Receive-domain asynchronous reset, active low |
| rx_regs_o | output | 320 | Receive-side copies, register r at bits [32r+31:32r] |

## Verification
The assertions assume that `big_end_i` changes only while every busy bit is 0. They also assume that both resets are applied together at start-up, so the request and acknowledge toggles begin equal. The stimulus waits for all busy bits to clear before it changes the mode or starts the next random write. The one exception is the directed overrun case, which writes into an in-flight register on purpose. Random writes use a random register, data, byte-enable pattern and mode, so triggering and non-triggering writes are mixed in both modes.

// File: rtl/addr_cdc_pkg.sv
package addr_cdc_pkg;
  localparam int L3_WORDS = 4;
  localparam int WORDS_PER_SET = L3_WORDS + 1;

  typedef enum logic {
    END_LITTLE = 1'b0,
    END_BIG    = 1'b1
  } endian_e;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hst_slot.sv
module hst_slot
  import addr_cdc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTES-1:0]  be_i,
  input  logic [DATA_W-1:0] data_i,
  input  endian_e           mode_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              req_o,
  output logic              busy_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] data_q, merged;
  logic req_q, ack_s, ovr_q, trig, busy;

  sync2 #(.W(1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  assign busy = req_q ^ ack_s;
  assign trig = (mode_i == END_BIG) ? be_i[0] : be_i[BYTES-1];

  always_comb begin
    merged = data_q;
    for (int k = 0; k < BYTES; k++)
      if (be_i[k]) merged[8*k +: 8] = data_i[8*k +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      req_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (wr_i) begin
      if (!busy) begin
        data_q <= merged;
        if (trig) req_q <= ~req_q;
      end else if (trig) begin
        ovr_q <= 1'b1;
      end
    end
  end

  assign data_o    = data_q;
  assign req_o     = req_q;
  assign busy_o    = busy;
  assign overrun_o = ovr_q;

  // R5
  busy_after_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !busy && trig |=> busy_o);
  // R6
  hold_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(data_q));
  // R6
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
  // R4
  no_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && trig) |=> $stable(req_q));
endmodule

// File: rtl/rx_slot.sv
module rx_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] copy_o,
  output logic              ack_o
);
  logic req_s, ack_q, load;
  logic [DATA_W-1:0] copy_q;

  sync2 #(.W(1)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  assign load = req_s ^ ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      copy_q <= '0;
    end else begin
      ack_q <= req_s;
      if (load) copy_q <= data_i;
    end
  end

  assign copy_o = copy_q;
  assign ack_o  = ack_q;

  // R4
  copy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(copy_o));
  // R2
  copy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> copy_o == $past(data_i));
endmodule

// File: rtl/addr_bank_cdc.sv
module addr_bank_cdc
  import addr_cdc_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int DATA_W   = 32,
  localparam int NUM_REGS = NUM_SETS * WORDS_PER_SET,
  localparam int ADDR_W   = $clog2(NUM_REGS + 1),
  localparam int BYTES    = DATA_W / 8
) (
  input  logic                       hclk_i,
  input  logic                       hrst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [BYTES-1:0]           wr_be_i,
  input  logic                       big_end_i,
  output logic [NUM_REGS-1:0]        busy_o,
  output logic [NUM_REGS-1:0]        overrun_o,
  input  logic                       rclk_i,
  input  logic                       rrst_ni,
  output logic [NUM_REGS*DATA_W-1:0] rx_regs_o
);
  endian_e mode;
  logic [NUM_REGS-1:0] hit, req, ack;
  logic [NUM_REGS*DATA_W-1:0] host_data;

  assign mode = big_end_i ? END_BIG : END_LITTLE;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign hit[r] = wr_en_i && (wr_addr_i == ADDR_W'(r));

    hst_slot #(.DATA_W(DATA_W)) u_hst (
      .clk_i    (hclk_i),
      .rst_ni   (hrst_ni),
      .wr_i     (hit[r]),
      .be_i     (wr_be_i),
      .data_i   (wr_data_i),
      .mode_i   (mode),
      .ack_i    (ack[r]),
      .data_o   (host_data[r*DATA_W +: DATA_W]),
      .req_o    (req[r]),
      .busy_o   (busy_o[r]),
      .overrun_o(overrun_o[r])
    );

    rx_slot #(.DATA_W(DATA_W)) u_rx (
      .clk_i (rclk_i),
      .rst_ni(rrst_ni),
      .req_i (req[r]),
      .data_i(host_data[r*DATA_W +: DATA_W]),
      .copy_o(rx_regs_o[r*DATA_W +: DATA_W]),
      .ack_o (ack[r])
    );
  end

  // R7
  bad_addr_chk: assert property (@(posedge hclk_i) disable iff (!hrst_ni)
    wr_en_i && (wr_addr_i >= ADDR_W'(NUM_REGS)) |=> $stable(host_data) && $stable(req));
  // R8
  one_hot_hit_chk: assert property (@(posedge hclk_i) disable iff (!hrst_ni)
    $onehot0(hit));
endmodule

// File: tb/addr_bank_cdc_tb_top.sv
module addr_bank_cdc_tb_top;
  localparam int HCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 7;
  localparam int NR = 10;

  logic hclk = 0, rclk = 0, hrst_n = 0, rrst_n = 0;
  logic wr_en = 0, big_end = 0;
  logic [3:0] wr_addr = '0, wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [NR-1:0] busy, overrun;
  logic [NR*32-1:0] rx_regs;

  int n_run = 0, n_fail = 0;
  logic [31:0] host_m [NR];
  logic [31:0] rx_m [NR];

  always #(HCLK_PERIOD/2) hclk = ~hclk;
  always #(RCLK_PERIOD/2.0) rclk = ~rclk;

  addr_bank_cdc dut_i (
    .hclk_i(hclk), .hrst_ni(hrst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .big_end_i(big_end),
    .busy_o(busy), .overrun_o(overrun), .rclk_i(rclk), .rrst_ni(rrst_n),
    .rx_regs_o(rx_regs)
  );

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] m = o;
    for (int k = 0; k < 4; k++) if (be[k]) m[8*k +: 8] = n[8*k +: 8];
    return m;
  endfunction

  function automatic logic is_trig(logic [3:0] be, logic bige);
    return bige ? be[0] : be[3];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all_rx(string req);
    for (int r = 0; r < NR; r++) chk(req, rx_regs[r*32 +: 32], rx_m[r]);
  endtask

  // model update assumes register idle
  task automatic wr(int a, logic [31:0] d, logic [3:0] be);
    @(negedge hclk);
    wr_en = 1; wr_addr = 4'(a); wr_data = d; wr_be = be;
    @(negedge hclk);
    wr_en = 0; wr_be = '0;
    if (a < NR) begin
      host_m[a] = merge(host_m[a], d, be);
      if (is_trig(be, big_end)) rx_m[a] = host_m[a];
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge rclk);
    #1;
    while (busy != '0) @(negedge hclk);
  endtask

  initial begin
    #(HCLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NR; r++) begin host_m[r] = '0; rx_m[r] = '0; end
    #(HCLK_PERIOD*3 + 1);
    hrst_n = 1; rrst_n = 1;
    @(negedge hclk);
    // R1
    chk_all_rx("R1");
    chk("R1 busy", 32'(busy), 0);
    chk("R1 overrun", 32'(overrun), 0);

    // R2 little-endian trigger, busy R5
    wr(0, 32'hC0A8_0101, 4'hF);
    chk("R5 busy rise", 32'(busy[0]), 1);
    repeat (4) @(posedge rclk); #1;
    chk("R2", rx_regs[0 +: 32], 32'hC0A8_0101);
    settle();
    chk("R5 busy clear", 32'(busy), 0);

    // R4 partial lanes do not transfer, then carried by trigger
    wr(7, 32'h1122_3344, 4'b0011);
    settle();
    chk_all_rx("R4");
    chk("R5 no busy", 32'(busy), 0);
    wr(7, 32'hAB00_0000, 4'b1000);
    repeat (4) @(posedge rclk); #1;
    chk("R4 carry", rx_regs[7*32 +: 32], 32'hAB00_3344);
    settle();

    // R3 big-endian: byte 0 triggers, byte 3 does not
    big_end = 1;
    wr(4, 32'h0000_1F90, 4'b0001);
    repeat (4) @(posedge rclk); #1;
    chk("R3 trig", rx_regs[4*32 +: 32], 32'h0000_0090);
    settle();
    wr(9, 32'hDEAD_BEEF, 4'b1110);
    settle();
    chk("R3 no trig", rx_regs[9*32 +: 32], 32'h0);
    chk_all_rx("R3");
    big_end = 0;

    // R6 overrun: second write while busy dropped
    wr(2, 32'h0A0B_0C0D, 4'hF);
    @(negedge hclk);
    wr_en = 1; wr_addr = 4'd2; wr_data = 32'h5555_5555; wr_be = 4'hF;
    @(negedge hclk);
    wr_en = 0; wr_be = '0;
    chk("R6 overrun", 32'(overrun), 32'h4);
    settle();
    chk("R6 first kept", rx_regs[2*32 +: 32], 32'h0A0B_0C0D);
    wr(2, 32'h7700_0000, 4'b1000);
    settle();
    chk("R6 host unchanged", rx_regs[2*32 +: 32], 32'h770B_0C0D);
    chk("R6 sticky", 32'(overrun), 32'h4);

    // R7 out of range
    wr(10, 32'hFFFF_FFFF, 4'hF);
    chk("R7 busy", 32'(busy), 0);
    wr(15, 32'hFFFF_FFFF, 4'hF);
    settle();
    chk_all_rx("R7");

    // random mix R2 R3 R4 R8
    for (int i = 0; i < 80; i++) begin
      int r = int'($urandom % NR);
      logic [31:0] d = $urandom;
      logic [3:0] be = 4'($urandom % 16);
      big_end = 1'($urandom % 2);
      @(negedge hclk);
      wr(r, d, be);
      settle();
      chk_all_rx(is_trig(be, big_end) ? "R8 rand trig" : "R8 rand partial");
    end
    chk("R6 final overrun", 32'(overrun), 32'h4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule